// File: doc/BRIEF.md
# UART Receive Queue with Character Timeout

This block holds the bytes a UART receiver has assembled until the host reads them. It is a first-in first-out store, sixteen entries of eight bits by default, with a fill-level trigger flag that can be set to one of four thresholds. It also has an idle detector that flags data left waiting in the queue. The receive deserializer pushes each finished byte and pulses a marker at the middle of each stop bit. The host pops the oldest byte through the holding-register read. The queue reports its fill count, whether any data is waiting, whether the selected threshold has been reached, and whether the line has been quiet too long while data remains.

The idle detector counts ticks of the 16x baud clock. Its limit is four whole character frames of the current line format. The count restarts on each stop-bit centre marker and on each host read. It stays at zero while the queue is empty. When the queue is switched off, it behaves as a single-byte holding register whose threshold is one.

Top module: `rxq_timeout_fifo`

## Requirements
- R1: After reset the count is 0, and data-ready, threshold, timeout and overrun outputs are all 0.
- R2: With the queue enabled, up to 16 bytes are held and read back oldest first on `rd_data_o`. `data_ready_o` is 1 exactly when the count is non-zero, and `rd_data_o` reads 0 while the queue is empty.
- R3: `trig_sel_i` codes 0, 1, 2 and 3 select thresholds of 1, 4, 8 and 14 bytes. `trig_hit_o` is 1 when the count is at or above the selected threshold, and the count may rise past it.
- R4: A push into a full queue with no pop in the same cycle is discarded. The count and the stored bytes are unchanged, and `overrun_o` is high for the one cycle after that push.
- R5: A push and a pop in the same cycle on a non-empty queue leave the count unchanged.
- R6: With `fifo_en_i` at 0 the capacity is one byte and the threshold is one, whatever `trig_sel_i` holds.
- R7: With data waiting and no restart, `timeout_o` rises after 4 x F ticks of `tick16_i` and not before. F is the frame length in ticks: 16 x (1 start + data bits + parity bit) + stop ticks. Data bits are `data_bits_i`+5, and the parity bit counts only when `parity_en_i` is 1. The stop field gives 16 ticks when `stop_sel_i` is 0. When `stop_sel_i` is 1 it gives 24 ticks for 5 data bits and 32 ticks otherwise.
- R8: A `stop_mid_i` pulse or a pop restarts the tick count from zero.
- R9: While the queue is empty the tick count is held at zero and `timeout_o` stays 0.
- R10: Once set, `timeout_o` stays 1 until a pop or a push occurs, or the queue empties.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Deserializer delivers a byte |
| push_data_i | input | 8 | Byte to store |
| stop_mid_i | input | 1 | Pulse at the centre of a received stop bit |
| pop_i | input | 1 | Host reads the holding register |
| fifo_en_i | input | 1 | 1 = queue mode, 0 = single-byte holding mode |
| trig_sel_i | input | 2 | Threshold select code |
| data_bits_i | input | 2 | Data bits minus five |
| parity_en_i | input | 1 | Parity bit present in the frame |
| stop_sel_i | input | 1 | 0 = one stop bit, 1 = long stop (1.5 or 2) |
| tick16_i | input | 1 | 16x baud tick enable |
| rd_data_o | output | 8 | Oldest stored byte |
| count_o | output | 5 | Bytes held |
| data_ready_o | output | 1 | At least one byte held |
| trig_hit_o | output | 1 | Count at or above threshold |
| timeout_o | output | 1 | Data waiting and line idle for four frames |
| overrun_o | output | 1 | One-cycle pulse after a discarded push |

## Verification
The assertions assume the mode input and the line format are changed only while the queue is empty and the line is quiet. They also assume a pop is issued only by a host that has seen data-ready, and that the stop-bit marker arrives together with, or just before, the matching push. The stimulus follows these rules. It sets the mode and format between scenarios, after draining the queue. It pairs each push with a stop-bit marker except where a requirement calls for a bare push or a bare marker. It steps the baud tick one cycle at a time, so that the exact tick on which the timeout rises can be observed.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   typedef enum logic [1:0] {
      TRIG_ONE     = 2'd0,
      TRIG_QUARTER = 2'd1,
      TRIG_HALF    = 2'd2,
      TRIG_NEAR    = 2'd3
   } trig_code_e;

   // Threshold scales with depth: 1, depth/4, depth/2, depth-2 (1,4,8,14 at 16).
   function automatic int trig_level(input int depth, input logic [1:0] code);
      case (trig_code_e'(code))
         TRIG_ONE:     return 1;
         TRIG_QUARTER: return depth / 4;
         TRIG_HALF:    return depth / 2;
         default:      return depth - 2;
      endcase
   endfunction

   // Frame length in half-bit units: start, data, optional parity, stop.
   function automatic int frame_half_bits(input logic [1:0] dbits,
                                          input logic par, input logic stop_long);
      int h;
      h = 2 * (1 + 5 + int'(dbits) + int'(par));
      if (!stop_long)          h = h + 2;
      else if (dbits == 2'd0)  h = h + 3;
      else                     h = h + 4;
      return h;
   endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int DW         = 8,
   parameter int DEPTH      = 16,
   parameter bit ZERO_EMPTY = 1'b1,
   localparam int AW        = $clog2(DEPTH),
   localparam int CW        = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          pop_i,
   input  logic          single_i,
   output logic [DW-1:0] rdata_o,
   output logic [CW-1:0] count_o,
   output logic          overrun_o
);

   localparam logic [CW-1:0] CAP_FULL = CW'(DEPTH);
   localparam logic [CW-1:0] CAP_ONE  = CW'(1);

   logic [AW-1:0] wr_ptr_q, rd_ptr_q;
   logic [CW-1:0] count_q;
   logic [CW-1:0] cap;
   logic          pop_ok, push_ok, overrun_q;
   logic [DW-1:0] slot_w [DEPTH];

   assign cap     = single_i ? CAP_ONE : CAP_FULL;
   assign pop_ok  = pop_i && (count_q != '0);
   assign push_ok = push_i && ((count_q < cap) || pop_ok);

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [DW-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (push_ok && (wr_ptr_q == AW'(i))) slot_q <= wdata_i;
      end
      assign slot_w[i] = slot_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q  <= '0;
         rd_ptr_q  <= '0;
         count_q   <= '0;
         overrun_q <= 1'b0;
      end else begin
         overrun_q <= push_i && !push_ok;
         if (push_ok) wr_ptr_q <= wr_ptr_q + AW'(1);
         if (pop_ok)  rd_ptr_q <= rd_ptr_q + AW'(1);
         case ({push_ok, pop_ok})
            2'b10:   count_q <= count_q + CW'(1);
            2'b01:   count_q <= count_q - CW'(1);
            default: count_q <= count_q;
         endcase
      end
   end

   if (ZERO_EMPTY) begin : g_rd_gated
      assign rdata_o = (count_q != '0) ? slot_w[rd_ptr_q] : '0;
   end else begin : g_rd_raw
      assign rdata_o = slot_w[rd_ptr_q];
   end

   assign count_o   = count_q;
   assign overrun_o = overrun_q;

   // R2
   count_le_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= cap);

   // R4
   overrun_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun_q |-> $past(push_i && !pop_ok && (count_q == cap)));

   // R5
   push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && pop_i && (count_q != '0)) |=> (count_q == $past(count_q)));

endmodule

// File: rtl/rxq_frame_len.sv
module rxq_frame_len #(
   parameter int TPB    = 16,
   parameter int WINDOW = 4,
   parameter int LW     = 10
) (
   input  logic [1:0]    data_bits_i,
   input  logic          parity_en_i,
   input  logic          stop_sel_i,
   output logic [LW-1:0] limit_o
);
   import rxq_pkg::*;

   int half_bits;

   always_comb begin
      half_bits = frame_half_bits(data_bits_i, parity_en_i, stop_sel_i);
      limit_o   = LW'(WINDOW * (TPB / 2) * half_bits);
   end

endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
   parameter int LW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic [LW-1:0] limit_i,
   input  logic          restart_i,
   input  logic          clear_i,
   input  logic          nonempty_i,
   output logic          timeout_o
);

   logic [LW-1:0] cnt_q;
   logic          to_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         to_q  <= 1'b0;
      end else if (!nonempty_i) begin
         cnt_q <= '0;
         to_q  <= 1'b0;
      end else begin
         if (restart_i) begin
            cnt_q <= '0;
         end else if (tick_i && !to_q) begin
            cnt_q <= cnt_q + LW'(1);
            if ((cnt_q + LW'(1)) >= limit_i) to_q <= 1'b1;
         end
         if (clear_i) to_q <= 1'b0;
      end
   end

   assign timeout_o = to_q;

   // R9
   empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !nonempty_i |=> !to_q);

   // R10
   timeout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (to_q && nonempty_i && !clear_i) |=> to_q);

   // R8
   restart_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> !$rose(to_q));

   // R7
   rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(to_q) |-> $past(tick_i));

endmodule

// File: rtl/rxq_timeout_fifo.sv
module rxq_timeout_fifo #(
   parameter int DW         = 8,
   parameter int DEPTH      = 16,
   parameter int TPB        = 16,
   parameter int WINDOW     = 4,
   parameter bit ZERO_EMPTY = 1'b1,
   localparam int CW        = $clog2(DEPTH + 1),
   localparam int MAX_BITS  = 12,
   localparam int LW        = $clog2(WINDOW * TPB * MAX_BITS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic [DW-1:0] push_data_i,
   input  logic          stop_mid_i,
   input  logic          pop_i,
   input  logic          fifo_en_i,
   input  logic [1:0]    trig_sel_i,
   input  logic [1:0]    data_bits_i,
   input  logic          parity_en_i,
   input  logic          stop_sel_i,
   input  logic          tick16_i,
   output logic [DW-1:0] rd_data_o,
   output logic [CW-1:0] count_o,
   output logic          data_ready_o,
   output logic          trig_hit_o,
   output logic          timeout_o,
   output logic          overrun_o
);
   import rxq_pkg::*;

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if (TPB < 2 || (TPB % 2) != 0) begin : g_bad_tpb
      $error("TPB must be even and at least 2");
   end
   if (DW < 1 || WINDOW < 1) begin : g_bad_misc
      $error("DW and WINDOW must be positive");
   end

   logic [CW-1:0] count_w;
   logic [LW-1:0] limit_w;
   int            level;

   rxq_store #(.DW(DW), .DEPTH(DEPTH), .ZERO_EMPTY(ZERO_EMPTY)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_i    (push_i),
      .wdata_i   (push_data_i),
      .pop_i     (pop_i),
      .single_i  (!fifo_en_i),
      .rdata_o   (rd_data_o),
      .count_o   (count_w),
      .overrun_o (overrun_o)
   );

   rxq_frame_len #(.TPB(TPB), .WINDOW(WINDOW), .LW(LW)) u_frame (
      .data_bits_i (data_bits_i),
      .parity_en_i (parity_en_i),
      .stop_sel_i  (stop_sel_i),
      .limit_o     (limit_w)
   );

   rxq_idle_timer #(.LW(LW)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick16_i),
      .limit_i    (limit_w),
      .restart_i  (stop_mid_i || pop_i),
      .clear_i    (pop_i || push_i),
      .nonempty_i (count_w != '0),
      .timeout_o  (timeout_o)
   );

   always_comb begin
      level = fifo_en_i ? trig_level(DEPTH, trig_sel_i) : 1;
   end

   assign count_o      = count_w;
   assign data_ready_o = (count_w != '0);
   assign trig_hit_o   = (int'(count_w) >= level);

endmodule

// File: tb/rxq_timeout_fifo_bench.sv
module rxq_timeout_fifo_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       push_i = 0, stop_mid_i = 0, pop_i = 0, tick16_i = 0;
   logic [7:0] push_data_i = '0;
   logic       fifo_en_i = 1'b1, parity_en_i = 1'b0, stop_sel_i = 1'b0;
   logic [1:0] trig_sel_i = '0, data_bits_i = 2'd3;
   logic [7:0] rd_data_o;
   logic [4:0] count_o;
   logic       data_ready_o, trig_hit_o, timeout_o, overrun_o;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   rxq_timeout_fifo u_rxq_timeout_fifo (
      .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
      .stop_mid_i(stop_mid_i), .pop_i(pop_i), .fifo_en_i(fifo_en_i),
      .trig_sel_i(trig_sel_i), .data_bits_i(data_bits_i),
      .parity_en_i(parity_en_i), .stop_sel_i(stop_sel_i), .tick16_i(tick16_i),
      .rd_data_o(rd_data_o), .count_o(count_o), .data_ready_o(data_ready_o),
      .trig_hit_o(trig_hit_o), .timeout_o(timeout_o), .overrun_o(overrun_o));

   // {data_bits[15:14], parity[13], stop_long[12], expected limit[11:0]}
   localparam logic [15:0] FRAME_VEC [6] = '{
      {2'd0, 1'b0, 1'b0, 12'd448},
      {2'd0, 1'b0, 1'b1, 12'd480},
      {2'd3, 1'b0, 1'b0, 12'd640},
      {2'd3, 1'b1, 1'b1, 12'd768},
      {2'd1, 1'b1, 1'b0, 12'd576},
      {2'd2, 1'b0, 1'b1, 12'd640}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic cycle(input logic psh, input logic [7:0] d, input logic stp,
                        input logic pp);
      push_i = psh; push_data_i = d; stop_mid_i = stp; pop_i = pp;
      @(posedge clk); #2;
      push_i = 0; stop_mid_i = 0; pop_i = 0;
   endtask

   task automatic ticks(input int n);
      tick16_i = 1'b1;
      repeat (n) @(posedge clk);
      #2;
      tick16_i = 1'b0;
   endtask

   task automatic drain();
      while (count_o != 0) cycle(0, 8'h00, 0, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
   end

   initial begin
      int lim;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 count", count_o, 0);
      chk("R1 flags", {data_ready_o, trig_hit_o, timeout_o, overrun_o}, 0);

      // R7 frame-length table walk
      foreach (FRAME_VEC[k]) begin
         data_bits_i = FRAME_VEC[k][15:14];
         parity_en_i = FRAME_VEC[k][13];
         stop_sel_i  = FRAME_VEC[k][12];
         lim         = int'(FRAME_VEC[k][11:0]);
         cycle(1, 8'h55, 1, 0);
         ticks(lim - 1);
         chk("R7 not yet", timeout_o, 0);
         ticks(1);
         chk("R7 rises", timeout_o, 1);
         cycle(0, 8'h00, 0, 1);
         chk("R10 pop clears", timeout_o, 0);
      end
      data_bits_i = 2'd3; parity_en_i = 0; stop_sel_i = 0; lim = 640;

      // R2 R3 fill with threshold checks
      for (int i = 1; i <= 16; i++) begin
         cycle(1, 8'hA0 + 8'(i), 1, 0);
         chk("R2 count", count_o, i);
         chk("R2 ready", data_ready_o, 1);
         for (int c = 0; c < 4; c++) begin
            int lv;
            lv = (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 14;
            trig_sel_i = 2'(c);
            #1;
            chk("R3 threshold", trig_hit_o, (i >= lv) ? 1 : 0);
         end
      end
      // R4 overrun when full
      cycle(1, 8'hEE, 1, 0);
      chk("R4 overrun pulse", overrun_o, 1);
      chk("R4 count kept", count_o, 16);
      cycle(0, 8'h00, 0, 0);
      chk("R4 pulse one cycle", overrun_o, 0);
      // R5 push+pop at full
      cycle(1, 8'hB1, 1, 1);
      chk("R5 count full", count_o, 16);
      // R2 order (first byte popped above, new byte at tail)
      for (int i = 2; i <= 16; i++) begin
         chk("R2 order", rd_data_o, 8'hA0 + i);
         cycle(0, 8'h00, 0, 1);
      end
      chk("R2 tail", rd_data_o, 8'hB1);
      cycle(0, 8'h00, 0, 1);
      chk("R2 empty ready", data_ready_o, 0);
      chk("R2 empty data", rd_data_o, 0);
      // R5 push+pop mid-level
      cycle(1, 8'h01, 1, 0);
      cycle(1, 8'h02, 1, 0);
      cycle(1, 8'h03, 1, 1);
      chk("R5 count mid", count_o, 2);
      chk("R5 head", rd_data_o, 8'h02);
      drain();

      // R6 holding mode
      fifo_en_i = 1'b0; trig_sel_i = 2'd3;
      cycle(1, 8'h3C, 1, 0);
      chk("R6 count one", count_o, 1);
      chk("R6 trig forced", trig_hit_o, 1);
      cycle(1, 8'h4D, 1, 0);
      chk("R6 overrun", overrun_o, 1);
      chk("R6 cap one", count_o, 1);
      chk("R6 kept byte", rd_data_o, 8'h3C);
      drain();
      fifo_en_i = 1'b1; trig_sel_i = 2'd0;

      // R8 restart on pop
      cycle(1, 8'h11, 1, 0);
      cycle(1, 8'h12, 1, 0);
      ticks(lim - 1);
      cycle(0, 8'h00, 0, 1);
      ticks(lim - 1);
      chk("R8 pop restart", timeout_o, 0);
      ticks(1);
      chk("R8 after pop", timeout_o, 1);
      // R10 hold through idle ticks
      ticks(50);
      chk("R10 holds", timeout_o, 1);
      cycle(1, 8'h13, 1, 0);
      chk("R10 push clears", timeout_o, 0);
      // R8 restart on stop marker alone
      ticks(lim - 10);
      cycle(0, 8'h00, 1, 0);
      ticks(lim - 1);
      chk("R8 stop restart", timeout_o, 0);
      ticks(1);
      chk("R8 after stop", timeout_o, 1);
      // R9 empty queue stays quiet
      drain();
      ticks(2 * lim);
      chk("R9 empty timeout", timeout_o, 0);
      chk("R9 empty count", count_o, 0);

      report();
   end

endmodule